// File: doc/BRIEF.md
# Backup Mode Release Controller

This block governs the exit from a low-power backup state and keeps a sticky indication of whether the contents of retained RAM can still be trusted. The only way out of backup is the release of the chip reset input (`chip_rst_n_i` going high). After that release the block runs a programmable oscillator-settling interval and only then raises its normal-operation output. Pulling the chip reset low again at any time sends it back to the backup state.

A status flag records retention loss. It is set on power application and whenever the backup-domain undervoltage comparator, brought in through a two-flop synchronizer, reports the backup supply below the retention level. Software clears the flag before it enters backup and reads it in the reset handler once the block has released. A value of 0 means retained data survived. A value of 1 means it was lost. Chip reset, the exit from backup and other supply events leave the flag untouched.

Top module: `bkup_release_ctrl`

## Requirements
- R1: While `por_i` is high, and after it falls, the state is backup: `normal_mode_o`=0, the config field (address 1, bits [2:0]) reads `SEL_RST` (default 3), and `bus_rdata_o` is 0 until the first read.
- R2: While `chip_rst_n_i` is low, `normal_mode_o` stays 0 whatever happens on the bus or the undervoltage input.
- R3: If `chip_rst_n_i` is first sampled high in backup at clock edge k, `normal_mode_o` rises after edge k+N, where N = 2^(STAB_BASE + sel) and sel is the config field value at edge k (STAB_BASE default 2).
- R4: `chip_rst_n_i` sampled low in any state forces `normal_mode_o` to 0 after that edge. The next release restarts the full interval.
- R5: `vbk_low_i` high at edge j sets the flag (`ram_lost_o`, status address 0 bit 0) after edge j+2.
- R6: Power-on (`por_i` high) sets the flag to 1. A flag of 0 means retained RAM is valid and 1 means it is invalid.
- R7: A write to address 0 with bit 0 = 1 clears the flag. A write of 0 at address 0, or a write at any other address, leaves it unchanged.
- R8: Asserting or releasing `chip_rst_n_i` never changes the flag.
- R9: When a synchronized undervoltage event and a clear write happen in the same cycle, the flag ends up 1.
- R10: A write to address 1 stores bits [2:0] as the interval selector, and a read of address 1 returns it in bits [2:0].
- R11: A read (sel=1, wr=0) presents its data on `bus_rdata_o` after the next edge. Unmapped addresses read 0, and `bus_rdata_o` holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on indication, synchronous active-high reset |
| chip_rst_n_i | input | 1 | Chip reset, low holds backup, high releases |
| vbk_low_i | input | 1 | Asynchronous flag: backup supply below retention level |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data |
| normal_mode_o | output | 1 | Normal operation mode active |
| ram_lost_o | output | 1 | Retention-loss flag |

## Verification
Each result arrives at a fixed delay after its stimulus. Read data appears one edge after the read. An undervoltage sample reaches the flag two edges later because of the synchronizer. Normal mode rises N edges after the edge that first samples the release, and it drops one edge after reset is sampled low. The bench models these delays behaviourally and compares every output on each falling edge, so a result that comes one cycle early or late shows up as a miscompare. The scenarios cover setting and clearing in the same cycle, a reset that cuts an interval short, and the shortest and longest selector values.

// File: rtl/bkr_pkg.sv
package bkr_pkg;
  typedef enum logic [1:0] {
    ST_BACKUP = 2'd0,
    ST_STAB   = 2'd1,
    ST_NORMAL = 2'd2
  } bkr_state_e;

  localparam int ADDR_STAT = 0;
  localparam int ADDR_CFG  = 1;
endpackage

// File: rtl/bkr_sync2.sv
module bkr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         por_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (por_i) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bkr_stab_timer.sv
module bkr_stab_timer #(
  parameter int STAB_BASE = 2,
  parameter int SELW      = 3
) (
  input  logic            clk,
  input  logic            por_i,
  input  logic            load_i,
  input  logic            run_i,
  input  logic [SELW-1:0] sel_i,
  output logic            done_o
);
  localparam int CW = STAB_BASE + (1 << SELW);
  localparam logic [CW-1:0] ONE = 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  always_comb begin
    load_val = (ONE << (STAB_BASE + int'(sel_i))) - ONE;
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign done_o = (cnt_q == '0);

  AST_TMR_STEP_DOWN: assert property (@(posedge clk) disable iff (por_i)
    (run_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (por_i)
    (done_o && !load_i) |=> done_o); // R3
endmodule

// File: rtl/bkr_fsm.sv
module bkr_fsm
  import bkr_pkg::*;
(
  input  logic clk,
  input  logic por_i,
  input  logic rel_i,
  input  logic tmr_done_i,
  output logic tmr_load_o,
  output logic tmr_run_o,
  output logic normal_o
);
  bkr_state_e state_q;
  bkr_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BACKUP: if (rel_i) state_d = ST_STAB;
      ST_STAB: begin
        if (!rel_i)          state_d = ST_BACKUP;
        else if (tmr_done_i) state_d = ST_NORMAL;
      end
      ST_NORMAL: if (!rel_i) state_d = ST_BACKUP;
      default: state_d = ST_BACKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_i) state_q <= ST_BACKUP;
    else       state_q <= state_d;
  end

  assign tmr_load_o = (state_q == ST_BACKUP) && rel_i;
  assign tmr_run_o  = (state_q == ST_STAB);
  assign normal_o   = (state_q == ST_NORMAL);

  AST_RST_FORCES_BACKUP: assert property (@(posedge clk) disable iff (por_i)
    !rel_i |=> (state_q == ST_BACKUP)); // R4
  AST_HOLD_IN_BACKUP: assert property (@(posedge clk) disable iff (por_i)
    (state_q == ST_BACKUP && !rel_i) |=> !normal_o); // R2
  AST_NO_EARLY_NORMAL: assert property (@(posedge clk) disable iff (por_i)
    (state_q == ST_STAB && !tmr_done_i) |=> (state_q != ST_NORMAL)); // R3
  AST_NORMAL_FROM_STAB: assert property (@(posedge clk) disable iff (por_i)
    $rose(normal_o) |-> ($past(state_q) == ST_STAB)); // R3
endmodule

// File: rtl/bkr_regs.sv
module bkr_regs
  import bkr_pkg::*;
#(
  parameter int             AW      = 2,
  parameter int             DW      = 8,
  parameter int             SELW    = 3,
  parameter logic [SELW-1:0] SEL_RST = 3
) (
  input  logic            clk,
  input  logic            por_i,
  input  logic            uv_sync_i,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            flag_o,
  output logic [SELW-1:0] sel_o
);
  logic            flag_q;
  logic [SELW-1:0] sel_q;
  logic [DW-1:0]   rdata_q;
  logic            hit_stat;
  logic            hit_cfg;
  logic            clr_wr;
  logic            cfg_wr;
  logic            rd_en;
  logic [DW-1:0]   rd_mux;

  assign hit_stat = (bus_addr_i == AW'(ADDR_STAT));
  assign hit_cfg  = (bus_addr_i == AW'(ADDR_CFG));
  assign clr_wr   = bus_sel_i && bus_wr_i && hit_stat && bus_wdata_i[0];
  assign cfg_wr   = bus_sel_i && bus_wr_i && hit_cfg;
  assign rd_en    = bus_sel_i && !bus_wr_i;

  always_comb begin
    rd_mux = '0;
    if (hit_stat)     rd_mux[0]      = flag_q;
    else if (hit_cfg) rd_mux[SELW-1:0] = sel_q;
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      flag_q  <= 1'b1;
      sel_q   <= SEL_RST;
      rdata_q <= '0;
    end else begin
      if (uv_sync_i)   flag_q <= 1'b1;
      else if (clr_wr) flag_q <= 1'b0;
      if (cfg_wr)      sel_q  <= bus_wdata_i[SELW-1:0];
      if (rd_en)       rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign flag_o      = flag_q;
  assign sel_o       = sel_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por_i)
    (flag_q && !clr_wr) |=> flag_q); // R7
  AST_UV_SETS_FLAG: assert property (@(posedge clk) disable iff (por_i)
    uv_sync_i |=> flag_q); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (por_i)
    (uv_sync_i && clr_wr) |=> flag_q); // R9
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (por_i)
    $rose(flag_q) |-> $past(uv_sync_i)); // R5
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (por_i)
    !rd_en |=> $stable(rdata_q)); // R11
endmodule

// File: rtl/bkup_release_ctrl.sv
module bkup_release_ctrl
  import bkr_pkg::*;
#(
  parameter int             AW        = 2,
  parameter int             DW        = 8,
  parameter int             STAB_BASE = 2,
  parameter int             SELW      = 3,
  parameter logic [SELW-1:0] SEL_RST   = 3
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          chip_rst_n_i,
  input  logic          vbk_low_i,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          normal_mode_o,
  output logic          ram_lost_o
);
  logic            uv_sync;
  logic [SELW-1:0] sel;
  logic            tmr_load;
  logic            tmr_run;
  logic            tmr_done;

  bkr_sync2 #(.W(1)) u_uv_sync (
    .clk   (clk),
    .por_i (por_i),
    .d_i   (vbk_low_i),
    .q_o   (uv_sync)
  );

  bkr_regs #(.AW(AW), .DW(DW), .SELW(SELW), .SEL_RST(SEL_RST)) u_regs (
    .clk         (clk),
    .por_i       (por_i),
    .uv_sync_i   (uv_sync),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .flag_o      (ram_lost_o),
    .sel_o       (sel)
  );

  bkr_stab_timer #(.STAB_BASE(STAB_BASE), .SELW(SELW)) u_timer (
    .clk    (clk),
    .por_i  (por_i),
    .load_i (tmr_load),
    .run_i  (tmr_run),
    .sel_i  (sel),
    .done_o (tmr_done)
  );

  bkr_fsm u_fsm (
    .clk        (clk),
    .por_i      (por_i),
    .rel_i      (chip_rst_n_i),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_run_o  (tmr_run),
    .normal_o   (normal_mode_o)
  );

  AST_NO_NORMAL_IN_RST: assert property (@(posedge clk) disable iff (por_i)
    !chip_rst_n_i |=> !normal_mode_o); // R4
  AST_RST_KEEPS_FLAG: assert property (@(posedge clk) disable iff (por_i)
    (!uv_sync && !(bus_sel_i && bus_wr_i)) |=> $stable(ram_lost_o)); // R8
endmodule

// File: tb/bkup_release_ctrl_tb.sv
module bkup_release_ctrl_tb;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int SEL_RST = 3;

  logic          clk = 1'b0;
  logic          por = 1'b1;
  logic          rel = 1'b0;
  logic          uv = 1'b0;
  logic          bsel = 1'b0;
  logic          bwr = 1'b0;
  logic [AW-1:0] baddr = '0;
  logic [DW-1:0] bwdata = '0;
  logic [DW-1:0] rdata;
  logic          normal;
  logic          lost;

  always #10 clk = ~clk;

  bkup_release_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk           (clk),
    .por_i         (por),
    .chip_rst_n_i  (rel),
    .vbk_low_i     (uv),
    .bus_sel_i     (bsel),
    .bus_wr_i      (bwr),
    .bus_addr_i    (baddr),
    .bus_wdata_i   (bwdata),
    .bus_rdata_o   (rdata),
    .normal_mode_o (normal),
    .ram_lost_o    (lost)
  );

  int    vectors = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    chk_en = 0;
  string cur = "R1";

  int m_state, m_cnt, m_sel, m_rdata;
  bit m_flag, m_s1, m_s2;

  always @(posedge clk) begin
    int o_sel;
    bit o_flag, o_s2;
    if (por) begin
      m_state = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0;
      m_flag = 1; m_sel = SEL_RST; m_rdata = 0;
    end else begin
      o_sel = m_sel; o_flag = m_flag; o_s2 = m_s2;
      if (bsel && !bwr)
        m_rdata = (baddr == 0) ? int'(o_flag) : (baddr == 1) ? o_sel : 0;
      if (o_s2) m_flag = 1;
      else if (bsel && bwr && baddr == 0 && bwdata[0]) m_flag = 0;
      m_s2 = m_s1;
      m_s1 = uv;
      if (bsel && bwr && baddr == 1) m_sel = int'(bwdata[2:0]);
      if (!rel) m_state = 0;
      else case (m_state)
        0: begin m_state = 1; m_cnt = (1 << (2 + o_sel)) - 1; end
        1: if (m_cnt == 0) m_state = 2; else m_cnt = m_cnt - 1;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      vectors++;
      if (normal !== (m_state == 2)) begin
        fails++;
        $display("FAIL %s normal_mode actual=%b expected=%b t=%0t", cur, normal, (m_state == 2), $time);
      end
      vectors++;
      if (lost !== m_flag) begin
        fails++;
        $display("FAIL %s ram_lost actual=%b expected=%b t=%0t", cur, lost, m_flag, $time);
      end
      vectors++;
      if (rdata !== DW'(m_rdata)) begin
        fails++;
        $display("FAIL %s rdata actual=%0h expected=%0h t=%0t", cur, rdata, m_rdata, $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bsel = 1; bwr = 1; baddr = AW'(a); bwdata = DW'(d);
    @(negedge clk);
    bsel = 0; bwr = 0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bsel = 1; bwr = 0; baddr = AW'(a);
    @(negedge clk);
    bsel = 0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    chk_en = 1;
    @(negedge clk); por = 0;
    // R1: state after power-on, default selector, zero read data
    cur = "R1"; cyc(2); rd(0); rd(1); cyc(1);
    // R7: clear only by writing 1 at address 0
    cur = "R7"; wr(0, 0); rd(0); wr(2, 1); rd(0); wr(0, 1); rd(0); rd(2); cyc(1);
    // R10: selector write and readback
    cur = "R10"; wr(1, 8'hF9); rd(1); cyc(1);
    // R2: bus activity while reset held low
    cur = "R2"; cyc(5); wr(0, 1); wr(3, 8'hFF); rd(1); cyc(5);
    // R3: interval of 8 (sel=1), then 4 (sel=0)
    cur = "R3"; @(negedge clk); rel = 1; cyc(15);
    rel = 0; cyc(2); wr(1, 0); @(negedge clk); rel = 1; cyc(8);
    // R4: reset cuts a 16-cycle interval short, then full restart
    cur = "R4"; rel = 0; cyc(2); wr(1, 2); @(negedge clk); rel = 1; cyc(6);
    rel = 0; cyc(1); rel = 1; cyc(20);
    // R8: reset toggles leave a clear flag clear
    cur = "R8"; rd(0); rel = 0; cyc(3); rel = 1; cyc(20); rd(0);
    // R5: one-cycle undervoltage pulse sets the flag two edges later
    cur = "R5"; @(negedge clk); uv = 1; @(negedge clk); uv = 0; cyc(4); rd(0);
    // R8: reset toggles leave a set flag set
    cur = "R8"; rel = 0; cyc(3); rel = 1; cyc(20); rd(0);
    // R9: set wins over a simultaneous clear
    cur = "R9"; @(negedge clk); uv = 1; cyc(4); wr(0, 1); rd(0);
    uv = 0; cyc(4); wr(0, 1); rd(0);
    // R11: read latency and longest interval (sel=7)
    cur = "R11"; wr(1, 7); rd(1); cyc(1); rd(0); rd(3);
    rel = 0; cyc(2); rel = 1; cyc(520);
    // R6: power-on sets the flag again
    cur = "R6"; @(negedge clk); por = 1; cyc(2); por = 0; rd(0); cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule